// File: doc/BRIEF.md
# Banked Configuration Register File for a Multi-Function I/O Controller

This block holds the standard configuration registers of a multi-function I/O controller that contains several logical devices. Software reaches every register through two byte ports. A byte written to the index port chooses a register. The data port then reads or writes the chosen register. One selector register, the device number, chooses which device's bank of per-device registers the data port reaches.

Each bank holds the following:
- an enable bit;
- two 16-bit I/O base addresses;
- an interrupt line number, with its polarity and trigger type;
- a DMA channel select.

Bits that have no function always read as zero. The block also drives every device's configuration in decoded form onto its outputs. These outputs include qualified interrupt-valid and DMA-valid flags, so a device never acts on an illegal interrupt number or on the "no channel" DMA code.

Top module: `sio_cfg_regs`

## Requirements
- R1: With `port_sel`=0, a write strobe stores `wdata` in the 8-bit index register. A read with `port_sel`=0 returns the index.
- R2: Index 0x07 is the device number register. All 8 bits can be written and read back through the data port (`port_sel`=1).
- R3: At index 0x30, bit 0 is the enable bit of the selected device and drives `dev_active`. Bits 7:1 read as 0.
- R4: Indices 0x60 and 0x61 hold base address 0 bits [15:8] and [7:0]. Indices 0x62 and 0x63 hold the same two halves of base address 1. They drive `io_base0` and `io_base1`, with 16 bits per device and device i at bits [16i+15:16i].
- R5: At index 0x70, bits 3:0 store the interrupt number, which drives `irq_num` (4 bits per device). Bits 7:4 read as 0.
- R6: At index 0x71, bit 1 is the polarity (1 means high) and drives `irq_high`. Bit 0 is the trigger type (1 means level) and drives `irq_level`. Bits 7:2 read as 0.
- R7: At index 0x74, bits 2:0 store the DMA select, which drives `dma_chan` (3 bits per device). Bits 7:3 read as 0.
- R8: The per-device indices reach only the bank chosen by the device number. Every other bank keeps its contents.
- R9: When the device number is NDEV (8) or more, per-device writes change no bank and per-device reads return 0.
- R10: `irq_valid[i]` is 1 exactly when device i is enabled and its interrupt number lies between 1 and 12.
- R11: `dma_valid[i]` is 1 exactly when device i is enabled and its DMA select is between 0 and 3. A select of 4 or more means the device has no channel.
- R12: After reset:
  - the index and device number are 0;
  - every device is disabled;
  - every base address is 0;
  - every interrupt number is 0, with polarity low and type edge;
  - every DMA select is 4.
- R13: Any index other than 0x07, 0x30, 0x60 to 0x63, 0x70, 0x71 and 0x74 reads as 0 through the data port, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected port, combinational |
| dev_active | output | NDEV | Enable bit of each device |
| io_base0 | output | 16*NDEV | Base address 0 of each device |
| io_base1 | output | 16*NDEV | Base address 1 of each device |
| irq_num | output | 4*NDEV | Interrupt number of each device |
| irq_high | output | NDEV | Interrupt polarity, 1 means high |
| irq_level | output | NDEV | Interrupt type, 1 means level |
| irq_valid | output | NDEV | Device enabled and interrupt number between 1 and 12 |
| dma_chan | output | 3*NDEV | Raw DMA select of each device |
| dma_valid | output | NDEV | Device enabled and DMA select between 0 and 3 |

## Verification
The assertions assume the following about the inputs:
- `wr_stb` lasts one cycle per access;
- `port_sel` and `wdata` are stable at the clock edge that samples the strobe;
- no input is X after reset.

The bench drives every input on the falling edge and drops `wr_stb` after a single cycle. It reads `rdata` only while no strobe is pending, so each read sees settled state. Device numbers at or above the bank count are driven on purpose, including 0x10, whose low bits alias bank 0. This checks that the qualified write paths hold.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam logic [7:0] IDX_DEVNUM = 8'h07;
    localparam logic [7:0] IDX_ACT    = 8'h30;
    localparam logic [7:0] IDX_B0H    = 8'h60;
    localparam logic [7:0] IDX_B0L    = 8'h61;
    localparam logic [7:0] IDX_B1H    = 8'h62;
    localparam logic [7:0] IDX_B1L    = 8'h63;
    localparam logic [7:0] IDX_IRQ    = 8'h70;
    localparam logic [7:0] IDX_IRQT   = 8'h71;
    localparam logic [7:0] IDX_DMA    = 8'h74;

    localparam logic [3:0] IRQ_TOP  = 4'd12;
    localparam logic [2:0] DMA_NONE = 3'd4;

    typedef enum logic [3:0] {
        RS_NONE, RS_DEVNUM, RS_ACT, RS_B0H, RS_B0L,
        RS_B1H, RS_B1L, RS_IRQ, RS_IRQT, RS_DMA
    } reg_sel_e;

    typedef struct packed {
        logic        active;
        logic [15:0] base0;
        logic [15:0] base1;
        logic [3:0]  irq;
        logic        pol_high;
        logic        lvl_trig;
        logic [2:0]  dma;
    } dev_cfg_t;

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] devnum;
    } host_st_t;

endpackage

// File: rtl/sio_idx_decode.sv
module sio_idx_decode
    import sio_cfg_pkg::*;
(
    input  logic [7:0] idx,
    output reg_sel_e   sel
);
    always_comb begin
        unique case (idx)
            IDX_DEVNUM: sel = RS_DEVNUM;
            IDX_ACT:    sel = RS_ACT;
            IDX_B0H:    sel = RS_B0H;
            IDX_B0L:    sel = RS_B0L;
            IDX_B1H:    sel = RS_B1H;
            IDX_B1L:    sel = RS_B1L;
            IDX_IRQ:    sel = RS_IRQ;
            IDX_IRQT:   sel = RS_IRQT;
            IDX_DMA:    sel = RS_DMA;
            default:    sel = RS_NONE;
        endcase
    end
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  reg_sel_e   sel,
    input  logic [7:0] wdata,
    output logic [7:0] rd,
    output dev_cfg_t   cfg,
    output logic       irq_ok,
    output logic       dma_ok
);
    dev_cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            unique case (sel)
                RS_ACT:  st_d.active      = wdata[0];
                RS_B0H:  st_d.base0[15:8] = wdata;
                RS_B0L:  st_d.base0[7:0]  = wdata;
                RS_B1H:  st_d.base1[15:8] = wdata;
                RS_B1L:  st_d.base1[7:0]  = wdata;
                RS_IRQ:  st_d.irq         = wdata[3:0];
                RS_IRQT: begin
                    st_d.pol_high = wdata[1];
                    st_d.lvl_trig = wdata[0];
                end
                RS_DMA:  st_d.dma         = wdata[2:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, base0: 16'h0, base1: 16'h0, irq: 4'h0,
                      pol_high: 1'b0, lvl_trig: 1'b0, dma: DMA_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (sel)
            RS_ACT:  rd = {7'b0, st_q.active};
            RS_B0H:  rd = st_q.base0[15:8];
            RS_B0L:  rd = st_q.base0[7:0];
            RS_B1H:  rd = st_q.base1[15:8];
            RS_B1L:  rd = st_q.base1[7:0];
            RS_IRQ:  rd = {4'b0, st_q.irq};
            RS_IRQT: rd = {6'b0, st_q.pol_high, st_q.lvl_trig};
            RS_DMA:  rd = {5'b0, st_q.dma};
            default: rd = 8'h00;
        endcase
    end

    assign cfg    = st_q;
    assign irq_ok = st_q.active && (st_q.irq != 4'd0) && (st_q.irq <= IRQ_TOP);
    assign dma_ok = st_q.active && (st_q.dma < DMA_NONE);

    // R8: without a write enable the bank holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q));
    // R4: a high-byte write of base 0 lands in the next cycle
    p_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == RS_B0H) |=> (cfg.base0[15:8] == $past(wdata)));
    // R5: the interrupt number takes the low nibble
    p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == RS_IRQ) |=> (cfg.irq == $past(wdata[3:0])));
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter int NDEV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_sel,
    input  logic              wr_stb,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [NDEV-1:0]   dev_active,
    output logic [16*NDEV-1:0] io_base0,
    output logic [16*NDEV-1:0] io_base1,
    output logic [4*NDEV-1:0] irq_num,
    output logic [NDEV-1:0]   irq_high,
    output logic [NDEV-1:0]   irq_level,
    output logic [NDEV-1:0]   irq_valid,
    output logic [3*NDEV-1:0] dma_chan,
    output logic [NDEV-1:0]   dma_valid
);
    localparam int SEL_W = (NDEV > 1) ? $clog2(NDEV) : 1;

    host_st_t st_d, st_q;
    reg_sel_e sel;
    logic     dev_ok;
    logic [SEL_W-1:0] bank_id;
    logic [7:0]       bank_rd [NDEV];
    dev_cfg_t         bank_cfg [NDEV];
    logic [NDEV-1:0]  bank_we;

    sio_idx_decode i_dec (.idx(st_q.index), .sel(sel));

    assign dev_ok  = (32'(st_q.devnum) < NDEV);
    assign bank_id = st_q.devnum[SEL_W-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            if (!port_sel) st_d.index = wdata;
            else if (sel == RS_DEVNUM) st_d.devnum = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar i = 0; i < NDEV; i++) begin : g_bank
            assign bank_we[i] = wr_stb && port_sel && dev_ok &&
                                (bank_id == SEL_W'(i));
            sio_dev_bank i_bank (
                .clk(clk), .rst_n(rst_n), .we(bank_we[i]), .sel(sel),
                .wdata(wdata), .rd(bank_rd[i]), .cfg(bank_cfg[i]),
                .irq_ok(irq_valid[i]), .dma_ok(dma_valid[i])
            );
            assign dev_active[i]         = bank_cfg[i].active;
            assign io_base0[16*i +: 16]  = bank_cfg[i].base0;
            assign io_base1[16*i +: 16]  = bank_cfg[i].base1;
            assign irq_num[4*i +: 4]     = bank_cfg[i].irq;
            assign irq_high[i]           = bank_cfg[i].pol_high;
            assign irq_level[i]          = bank_cfg[i].lvl_trig;
            assign dma_chan[3*i +: 3]    = bank_cfg[i].dma;

            // R11: a valid DMA flag never carries the "no channel" code
            p_dma_r11: assert property (@(posedge clk) disable iff (!rst_n)
                dma_valid[i] |-> (dma_chan[3*i +: 3] < DMA_NONE));
            // R10: a valid interrupt always belongs to an enabled device
            p_irq_act_r10: assert property (@(posedge clk) disable iff (!rst_n)
                irq_valid[i] |-> (dev_active[i] && irq_num[4*i +: 4] != 4'd0));
        end
    endgenerate

    always_comb begin
        if (!port_sel)              rdata = st_q.index;
        else if (sel == RS_DEVNUM)  rdata = st_q.devnum;
        else if (dev_ok)            rdata = bank_rd[bank_id];
        else                        rdata = 8'h00;
    end

    // R7: reserved DMA select bits read as zero at the port
    p_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (port_sel && sel == RS_DMA) |-> (rdata[7:3] == 5'b0));
    // R9: an out-of-range device number leaves every bank unchanged
    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && port_sel && !dev_ok) |=>
        ($stable(dev_active) && $stable(io_base0) && $stable(io_base1) &&
         $stable(irq_num) && $stable(dma_chan)));
endmodule

// File: tb/test_sio_cfg_regs.sv
module test_sio_cfg_regs;
    localparam int NDEV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_sel = 1'b0;
    logic wr_stb = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [NDEV-1:0] dev_active, irq_high, irq_level, irq_valid, dma_valid;
    logic [16*NDEV-1:0] io_base0, io_base1;
    logic [4*NDEV-1:0] irq_num;
    logic [3*NDEV-1:0] dma_chan;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sio_cfg_regs #(.NDEV(NDEV)) i_sio_cfg_regs (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_stb(wr_stb),
        .wdata(wdata), .rdata(rdata), .dev_active(dev_active),
        .io_base0(io_base0), .io_base1(io_base1), .irq_num(irq_num),
        .irq_high(irq_high), .irq_level(irq_level), .irq_valid(irq_valid),
        .dma_chan(dma_chan), .dma_valid(dma_valid)
    );

    // vector: write flag, port, data (write value or expected read), requirement id
    typedef struct packed {
        logic       wr;
        logic       port;
        logic [7:0] data;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 56;
    localparam vec_t VECS [NV] = '{
        '{1,0,8'h07,2}, '{1,1,8'h03,2}, '{0,1,8'h03,2}, '{0,0,8'h07,1},
        '{1,0,8'h30,3}, '{1,1,8'hFF,3}, '{0,1,8'h01,3},
        '{1,0,8'h60,4}, '{1,1,8'h12,4}, '{1,0,8'h61,4}, '{1,1,8'h34,4},
        '{1,0,8'h62,4}, '{1,1,8'hAB,4}, '{1,0,8'h63,4}, '{1,1,8'hCD,4},
        '{1,0,8'h61,4}, '{0,1,8'h34,4}, '{1,0,8'h62,4}, '{0,1,8'hAB,4},
        '{1,0,8'h70,5}, '{1,1,8'hF5,5}, '{0,1,8'h05,5},
        '{1,0,8'h71,6}, '{1,1,8'hFE,6}, '{0,1,8'h02,6},
        '{1,0,8'h74,7}, '{1,1,8'hFA,7}, '{0,1,8'h02,7},
        '{1,0,8'h07,8}, '{1,1,8'h05,8}, '{1,0,8'h70,8}, '{0,1,8'h00,8},
        '{1,0,8'h74,8}, '{0,1,8'h04,8},
        '{1,0,8'h07,8}, '{1,1,8'h03,8}, '{1,0,8'h70,8}, '{0,1,8'h05,8},
        '{1,0,8'h07,9}, '{1,1,8'h10,9}, '{0,1,8'h10,9},
        '{1,0,8'h30,9}, '{1,1,8'h01,9}, '{0,1,8'h00,9},
        '{1,0,8'h07,9}, '{1,1,8'h00,9}, '{1,0,8'h30,9}, '{0,1,8'h00,9},
        '{1,0,8'h07,13}, '{1,1,8'h03,13},
        '{1,0,8'h40,13}, '{1,1,8'hFF,13}, '{0,1,8'h00,13},
        '{1,0,8'h31,13}, '{1,1,8'hFF,13}, '{0,1,8'h00,13}
    };

    function automatic string rname(int n);
        case (n)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11"; 12: return "R12";
            13: return "R13"; default: return "R?";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic p, logic [7:0] d);
        @(negedge clk);
        port_sel = p; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd_chk(logic p, logic [7:0] exp, string req);
        port_sel = p;
        #1;
        check(req, 32'(rdata), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        rd_chk(1'b0, 8'h00, "R12");
        check("R12", 32'(dev_active), 32'h0);
        check("R12", 32'(dma_chan), 32'(24'o44444444));
        check("R12", 32'(irq_valid | dma_valid | irq_high | irq_level), 32'h0);
        check("R12", 32'(io_base0[31:0] | io_base1[31:0]), 32'h0);
        wr(1'b0, 8'h07);
        rd_chk(1'b1, 8'h00, "R12");

        for (int k = 0; k < NV; k++) begin
            if (VECS[k].wr) wr(VECS[k].port, VECS[k].data);
            else rd_chk(VECS[k].port, VECS[k].data, rname(int'(VECS[k].req)));
        end

        // decoded outputs of device 3
        #1;
        check("R3", 32'(dev_active), 32'h08);
        check("R4", 32'(io_base0[16*3 +: 16]), 32'h1234);
        check("R4", 32'(io_base1[16*3 +: 16]), 32'hABCD);
        check("R5", 32'(irq_num[4*3 +: 4]), 32'h5);
        check("R6", 32'({irq_high[3], irq_level[3]}), 32'h2);
        check("R7", 32'(dma_chan[3*3 +: 3]), 32'h2);
        check("R8", 32'(io_base0[16*5 +: 16]), 32'h0);
        check("R10", 32'(irq_valid), 32'h08);
        check("R11", 32'(dma_valid), 32'h08);

        // interrupt number boundaries (device 3 still selected)
        wr(1'b0, 8'h70);
        wr(1'b1, 8'h0D); #1; check("R10", 32'(irq_valid[3]), 32'h0);
        wr(1'b1, 8'h00); #1; check("R10", 32'(irq_valid[3]), 32'h0);
        wr(1'b1, 8'h0C); #1; check("R10", 32'(irq_valid[3]), 32'h1);
        wr(1'b1, 8'h01); #1; check("R10", 32'(irq_valid[3]), 32'h1);
        // DMA select boundaries
        wr(1'b0, 8'h74);
        wr(1'b1, 8'h04); #1; check("R11", 32'(dma_valid[3]), 32'h0);
        wr(1'b1, 8'h07); #1; check("R11", 32'(dma_valid[3]), 32'h0);
        wr(1'b1, 8'h03); #1; check("R11", 32'(dma_valid[3]), 32'h1);
        wr(1'b1, 8'h00); #1; check("R11", 32'(dma_valid[3]), 32'h1);
        // disabling drops both flags
        wr(1'b0, 8'h30);
        wr(1'b1, 8'h00); #1;
        check("R10", 32'(irq_valid[3]), 32'h0);
        check("R11", 32'(dma_valid[3]), 32'h0);
        check("R3", 32'(dev_active), 32'h0);

        // reset in mid-run
        wr(1'b1, 8'h01);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R12", 32'(dev_active), 32'h0);
        check("R12", 32'(dma_chan[3*3 +: 3]), 32'h4);
        check("R12", 32'(io_base0[16*3 +: 16]), 32'h0);
        rd_chk(1'b0, 8'h00, "R12");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule